// File: doc/BRIEF.md
# DS3 Frame-Slave Transmit Payload Interface

This block sits between an upstream terminal that supplies serial DS3 payload bits and a transmit framer that fills in the overhead bits. It runs as a frame slave. The terminal marks the start of each outbound frame with a one-clock reference pulse, and the block keeps a bit counter that tracks the position inside the 4760-bit frame. The frame is built from 7 subframes. Each subframe holds 8 blocks, and each block is one overhead slot followed by 84 payload slots. With no reference pulse, the counter wraps by itself. When a reference pulse arrives at an unexpected position, the counter is forced back into alignment.

One clock before every overhead slot, the block raises an early-warning strobe. The terminal responds by holding back its next payload bit for one clock, so no payload is consumed in an overhead slot. On the way downstream the block passes the payload bit stream, flags the overhead slots together with the kind of overhead bit each one holds, and reports the frame position, a 1-based payload index and a one-clock frame-start pulse.

The block works only in this serial frame-slave mode. That mode is selected by a 2-bit timing-reference field in an 8-bit operating-mode register and by a serial/nibble select pin.

Top module: `ds3s_slave_tx_if`

## Requirements
- R1: During and after synchronous active-low reset, `bit_pos` is 0, `ohd_ind` is low and the operating-mode register reads 0x00.
- R2: A write with `cfg_we` high and `cfg_addr` = 0x00 stores all 8 bits of `cfg_wdata` at the clock edge. `cfg_rdata` returns the stored byte when `cfg_addr` is 0x00 and 0x00 for any other address. Writes to other addresses change nothing.
- R3: The block is active only when register bits [1:0] equal 2'b01 and `nib_mode` is low. While it is inactive, the counter is loaded with 0 at each edge, and `ohd_ind`, `tx_oh`, `tx_data`, `frame_start`, `pay_idx` and `oh_type` are 0.
- R4: While active with no reference pulse, `bit_pos` increases by 1 per clock and goes from 4759 to 0.
- R5: If `frame_ref` is high at a clock edge while the block is active, `bit_pos` is 0 in the next cycle, whatever the position was.
- R6: While active, a position with `bit_pos` mod 85 = 0 is an overhead slot. In that slot `tx_oh` is 1, `tx_data` is 0 and `pay_idx` is 0.
- R7: While active, `ohd_ind` is high in exactly those cycles whose next slot is an overhead slot. That is the case when `bit_pos` mod 85 = 84 or when `frame_ref` is high.
- R8: While active, in a payload slot `tx_data` equals `pay_in` in the same cycle, and `pay_idx` equals `bit_pos` − floor(`bit_pos`/85), which runs from 1 to 4704 across the frame.
- R9: `oh_type` encodes the kind of overhead slot as none=0, X=1, P=2, M=3, F=4, C=5. Block 0 of subframes 0–1 is X, of subframes 2–3 is P and of subframes 4–6 is M. Odd blocks are F, and even blocks 2, 4 and 6 are C. Here block = floor(`bit_pos`/85) mod 8 and subframe = floor(`bit_pos`/680).
- R10: `frame_start` is high exactly when the block is active and `bit_pos` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Transmit input clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_we | input | 1 | Register write strobe |
| cfg_addr | input | 8 | Register address |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Register read data |
| nib_mode | input | 1 | High selects nibble mode (block idle) |
| frame_ref | input | 1 | Frame reference pulse from the terminal |
| pay_in | input | 1 | Serial payload bit from the terminal |
| tx_data | output | 1 | Payload bit stream, 0 in overhead slots |
| tx_oh | output | 1 | Current slot is an overhead slot |
| oh_type | output | 3 | Kind of overhead slot |
| ohd_ind | output | 1 | Early-warning strobe before each overhead slot |
| frame_start | output | 1 | First slot of a frame |
| bit_pos | output | 13 | Position inside the frame, 0..4759 |
| pay_idx | output | 13 | 1-based payload index, 0 in overhead slots |

## Verification
The counter is first run through whole frames with no reference pulse. This separates a correct modulus and block/subframe rollover from a slip of one position, and it covers every overhead kind and the payload index at each block edge. Reference pulses then arrive at the last position, at position 84, at position 0 and at random positions. These cases show whether the early strobe also follows a forced reload and whether resynchronisation happens at any position. Finally, register writes to the wrong address, other timing-reference codes and nibble mode check that the block goes quiet in every case and restarts cleanly at position 0.

// File: rtl/ds3s_pkg.sv
// Shared constants and types for the DS3 frame-slave transmit interface.
// Assumes the standard DS3 M-frame geometry: SUBS subframes of BLKS_PER_SUB
// blocks, each block one overhead slot followed by BLK_PAY payload slots.
package ds3s_pkg;

    parameter int BLK_PAY      = 84;
    parameter int BLKS_PER_SUB = 8;
    parameter int SUBS         = 7;

    localparam int BLK_LEN   = BLK_PAY + 1;
    localparam int SUB_LEN   = BLK_LEN * BLKS_PER_SUB;
    localparam int FRAME_LEN = SUB_LEN * SUBS;
    localparam int PAY_LEN   = BLK_PAY * BLKS_PER_SUB * SUBS;
    localparam int POS_W     = $clog2(FRAME_LEN);
    localparam int BB_W      = $clog2(BLK_LEN);
    localparam int BK_W      = $clog2(BLKS_PER_SUB);
    localparam int SB_W      = $clog2(SUBS);

    localparam logic [7:0] OPMODE_ADDR = 8'h00;
    localparam logic [1:0] TREF_SLAVE  = 2'b01;

    typedef enum logic [2:0] {
        OHK_NONE = 3'd0,
        OHK_X    = 3'd1,
        OHK_P    = 3'd2,
        OHK_M    = 3'd3,
        OHK_F    = 3'd4,
        OHK_C    = 3'd5
    } oh_kind_e;

    typedef struct packed {
        logic       lpbk_en;
        logic       e3_sel;
        logic       los_int_en;
        logic       soft_rst;
        logic       irq_en_rst;
        logic       fmt_sel;
        logic [1:0] tref_sel;
    } opmode_t;

endpackage

// File: rtl/ds3s_opmode_reg.sv
// Operating-mode register: one 8-bit read/write register at OPMODE_ADDR.
// Assumes single-cycle writes; reads are combinational from the address.
// Only the timing-reference field leaves the module as a decoded output.
module ds3s_opmode_reg
    import ds3s_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       we,
    input  logic [7:0] addr,
    input  logic [7:0] wdata,
    output logic [7:0] rdata,
    output logic [1:0] tref_sel
);

    opmode_t mode_q;
    logic    hit;

    // Address decode shared by write and read paths.
    assign hit = (addr == OPMODE_ADDR);

    // Register storage with synchronous clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= '0;
        end else if (we && hit) begin
            mode_q <= opmode_t'(wdata);
        end
    end

    // Read mux: unmapped addresses return zero.
    always_comb begin
        rdata = hit ? 8'(mode_q) : 8'h00;
    end

    assign tref_sel = mode_q.tref_sel;

endmodule

// File: rtl/ds3s_frame_ctr.sv
// Frame position counter, split into bit-in-block, block and subframe
// fields plus a flat position and the payload count before this block.
// Assumes ref_in is synchronous to clk; a reference reloads position 0.
module ds3s_frame_ctr
    import ds3s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             ref_in,
    output logic [BB_W-1:0]  bb,
    output logic [BK_W-1:0]  blk,
    output logic [SB_W-1:0]  sub,
    output logic [POS_W-1:0] pos,
    output logic [POS_W-1:0] pay_base
);

    logic bb_last, blk_last, sub_last, pos_last;

    // Terminal-count flags for each counter field.
    always_comb begin
        bb_last  = (bb  == BB_W'(BLK_LEN - 1));
        blk_last = (blk == BK_W'(BLKS_PER_SUB - 1));
        sub_last = (sub == SB_W'(SUBS - 1));
        pos_last = (pos == POS_W'(FRAME_LEN - 1));
    end

    // Advance, wrap, or reload all counter fields together.
    always_ff @(posedge clk) begin
        if (!rst_n || !run || ref_in) begin
            bb       <= '0;
            blk      <= '0;
            sub      <= '0;
            pos      <= '0;
            pay_base <= '0;
        end else begin
            pos <= pos_last ? '0 : pos + POS_W'(1);
            if (bb_last) begin
                bb <= '0;
                if (blk_last) begin
                    blk <= '0;
                    if (sub_last) begin
                        sub      <= '0;
                        pay_base <= '0;
                    end else begin
                        sub      <= sub + SB_W'(1);
                        pay_base <= pay_base + POS_W'(BLK_PAY);
                    end
                end else begin
                    blk      <= blk + BK_W'(1);
                    pay_base <= pay_base + POS_W'(BLK_PAY);
                end
            end else begin
                bb <= bb + BB_W'(1);
            end
        end
    end

endmodule

// File: rtl/ds3s_oh_decode.sv
// Overhead-slot decoder: flags slot 0 of every block and names its kind
// from block and subframe. Assumes the X,X,P,P,M,M,M first-bit order and
// F on odd blocks, C on even non-zero blocks.
module ds3s_oh_decode
    import ds3s_pkg::*;
(
    input  logic [BB_W-1:0] bb,
    input  logic [BK_W-1:0] blk,
    input  logic [SB_W-1:0] sub,
    output logic            is_oh,
    output oh_kind_e        kind
);

    oh_kind_e first_kind;

    // Kind of the first overhead bit of a subframe.
    always_comb begin
        if (sub < SB_W'(2))      first_kind = OHK_X;
        else if (sub < SB_W'(4)) first_kind = OHK_P;
        else                     first_kind = OHK_M;
    end

    // Slot flag and kind selection per block.
    always_comb begin
        is_oh = (bb == '0);
        if (!is_oh)           kind = OHK_NONE;
        else if (blk == '0)   kind = first_kind;
        else if (blk[0])      kind = OHK_F;
        else                  kind = OHK_C;
    end

endmodule

// File: rtl/ds3s_slave_tx_if.sv
// Top of the DS3 frame-slave transmit payload interface. Builds frame
// timing from the terminal's reference pulse, warns one clock ahead of each
// overhead slot and marks slots downstream. Assumes all inputs synchronous.
module ds3s_slave_tx_if
    import ds3s_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [7:0]       cfg_addr,
    input  logic [7:0]       cfg_wdata,
    output logic [7:0]       cfg_rdata,
    input  logic             nib_mode,
    input  logic             frame_ref,
    input  logic             pay_in,
    output logic             tx_data,
    output logic             tx_oh,
    output logic [2:0]       oh_type,
    output logic             ohd_ind,
    output logic             frame_start,
    output logic [POS_W-1:0] bit_pos,
    output logic [POS_W-1:0] pay_idx
);

    logic [1:0]       tref_sel;
    logic             mode_active;
    logic [BB_W-1:0]  bb;
    logic [BK_W-1:0]  blk;
    logic [SB_W-1:0]  sub;
    logic [POS_W-1:0] pay_base;
    logic             is_oh;
    oh_kind_e         kind;

    ds3s_opmode_reg u_reg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we       (cfg_we),
        .addr     (cfg_addr),
        .wdata    (cfg_wdata),
        .rdata    (cfg_rdata),
        .tref_sel (tref_sel)
    );

    // Mode qualifier: serial frame-slave operation only.
    assign mode_active = (tref_sel == TREF_SLAVE) && !nib_mode;

    ds3s_frame_ctr u_ctr (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (mode_active),
        .ref_in   (frame_ref),
        .bb       (bb),
        .blk      (blk),
        .sub      (sub),
        .pos      (bit_pos),
        .pay_base (pay_base)
    );

    ds3s_oh_decode u_dec (
        .bb    (bb),
        .blk   (blk),
        .sub   (sub),
        .is_oh (is_oh),
        .kind  (kind)
    );

    // Output gating and payload indexing.
    always_comb begin
        tx_oh       = mode_active && is_oh;
        tx_data     = mode_active && !is_oh && pay_in;
        oh_type     = mode_active ? 3'(kind) : 3'(OHK_NONE);
        frame_start = mode_active && (bit_pos == '0);
        ohd_ind     = mode_active && (frame_ref || bb == BB_W'(BLK_LEN - 1));
        pay_idx     = (mode_active && !is_oh) ? pay_base + POS_W'(bb) : '0;
    end

endmodule

// File: rtl/ds3s_checker.sv
// Temporal checks for ds3s_slave_tx_if, attached with bind below.
// Assumes synchronous active-low reset; past_ok guards $past after reset.
module ds3s_checker
    import ds3s_pkg::*;
(
    input logic             clk,
    input logic             rst_n,
    input logic             mode_active,
    input logic             frame_ref,
    input logic             ohd_ind,
    input logic             tx_oh,
    input logic             frame_start,
    input logic [POS_W-1:0] bit_pos,
    input logic [POS_W-1:0] pay_idx
);

    logic past_ok;

    // Marks that at least one post-reset edge has been seen.
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    p_pos_range_r4: assert property (@(posedge clk) disable iff (!rst_n)
        bit_pos < POS_W'(FRAME_LEN));

    p_wrap_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && bit_pos == POS_W'(FRAME_LEN - 1)) |=> (bit_pos == '0));

    p_ref_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_active && frame_ref) |=> (bit_pos == '0));

    p_ind_leads_oh_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ohd_ind |=> (tx_oh || !mode_active));

    p_oh_was_warned_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_ok && tx_oh && $past(mode_active)) |-> $past(ohd_ind));

    p_oh_no_payidx_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tx_oh |-> (pay_idx == '0));

    p_quiet_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !mode_active |-> (!ohd_ind && !tx_oh && !frame_start));

endmodule

bind ds3s_slave_tx_if ds3s_checker u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mode_active (mode_active),
    .frame_ref   (frame_ref),
    .ohd_ind     (ohd_ind),
    .tx_oh       (tx_oh),
    .frame_start (frame_start),
    .bit_pos     (bit_pos),
    .pay_idx     (pay_idx)
);

// File: tb/ds3s_slave_tx_if_tb.sv
module ds3s_slave_tx_if_tb;
    import ds3s_pkg::*;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [7:0]       cfg_addr = 8'h00;
    logic [7:0]       cfg_wdata = 8'h00;
    logic [7:0]       cfg_rdata;
    logic             nib_mode = 1'b0;
    logic             frame_ref = 1'b0;
    logic             pay_in = 1'b0;
    logic             tx_data, tx_oh, ohd_ind, frame_start;
    logic [2:0]       oh_type;
    logic [POS_W-1:0] bit_pos, pay_idx;

    int         n_chk = 0;
    int         n_fail = 0;
    bit         done = 0;
    logic [7:0] m_reg = 8'h00;
    int         m_pos = 0;

    ds3s_slave_tx_if u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_addr(cfg_addr),
        .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .nib_mode(nib_mode),
        .frame_ref(frame_ref), .pay_in(pay_in), .tx_data(tx_data),
        .tx_oh(tx_oh), .oh_type(oh_type), .ohd_ind(ohd_ind),
        .frame_start(frame_start), .bit_pos(bit_pos), .pay_idx(pay_idx)
    );

    always #10 clk = ~clk;

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s pos=%0d actual=%0d expected=%0d", tag, m_pos, act, exp);
        end
    endtask

    function automatic int f_kind(input int p);
        int bk, sb;
        if (p % 85 != 0) return 0;
        bk = (p / 85) % 8;
        sb = p / 680;
        if (bk == 0) return (sb < 2) ? 1 : (sb < 4) ? 2 : 3;
        return (bk % 2 == 1) ? 4 : 5;
    endfunction

    function automatic int f_payidx(input int p);
        return (p % 85 == 0) ? 0 : p - p / 85;
    endfunction

    // One cycle: drive at the falling edge, check, then advance the model.
    task automatic cyc(input bit we, input logic [7:0] a, input logic [7:0] d,
                       input bit nib, input bit rf, input bit pin);
        bit act, oh;
        cfg_we = we; cfg_addr = a; cfg_wdata = d;
        nib_mode = nib; frame_ref = rf; pay_in = pin;
        #2;
        act = (m_reg[1:0] == 2'b01) && !nib;
        oh  = (m_pos % 85 == 0);
        chk(cfg_rdata == ((a == 8'h00) ? m_reg : 8'h00), "R2 rdata", cfg_rdata, (a == 8'h00) ? m_reg : 0);
        chk(int'(bit_pos) == m_pos, "R4/R5 bit_pos", bit_pos, m_pos);
        chk(tx_oh == (act && oh), "R6 tx_oh", tx_oh, act && oh);
        chk(tx_data == (act && !oh && pin), "R8 tx_data", tx_data, act && !oh && pin);
        chk(int'(pay_idx) == (act ? f_payidx(m_pos) : 0), "R8 pay_idx", pay_idx, act ? f_payidx(m_pos) : 0);
        chk(int'(oh_type) == (act ? f_kind(m_pos) : 0), "R9 oh_type", oh_type, act ? f_kind(m_pos) : 0);
        chk(ohd_ind == (act && (rf || m_pos % 85 == 84)), "R7 ohd_ind", ohd_ind, act && (rf || m_pos % 85 == 84));
        chk(frame_start == (act && m_pos == 0), "R10 frame_start", frame_start, act && m_pos == 0);
        if (!act) chk(!ohd_ind && !tx_oh && !tx_data, "R3 idle quiet", ohd_ind, 0);
        @(posedge clk);
        if (we && a == 8'h00) m_reg = d;
        if (!act || rf) m_pos = 0;
        else m_pos = (m_pos == FRAME_LEN - 1) ? 0 : m_pos + 1;
        @(negedge clk);
    endtask

    task automatic run_to(input int p);
        for (int k = 0; k < 5000 && m_pos != p; k++) cyc(0, 8'h00, 8'h00, 0, 0, 1'($urandom));
    endtask

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        cfg_addr = 8'h00;
        #2;
        chk(bit_pos == '0, "R1 reset pos", bit_pos, 0);
        chk(ohd_ind == 1'b0, "R1 reset ind", ohd_ind, 0);
        chk(cfg_rdata == 8'h00, "R1 reset reg", cfg_rdata, 0);
        @(negedge clk);
        rst_n = 1'b1;
        // Idle after reset: register still zero (R3).
        repeat (5) cyc(0, 8'h00, 8'h00, 0, 0, 1);
        // Write to an unmapped address is ignored (R2).
        cyc(1, 8'h05, 8'h01, 0, 0, 1);
        cyc(0, 8'h05, 8'h00, 0, 0, 1);
        chk(cfg_rdata == 8'h00, "R2 unmapped read", cfg_rdata, 0);
        // Enable slave mode with other fields set (R2, R3).
        cyc(1, 8'h00, 8'hA5, 0, 0, 1);
        cyc(0, 8'h00, 8'h00, 0, 0, 0);
        cyc(1, 8'h00, 8'hF1, 0, 0, 1);
        // Full frame free-running plus wrap (R4, R6, R7, R9).
        run_to(FRAME_LEN - 1);
        cyc(0, 8'h00, 8'h00, 0, 0, 1);
        chk(m_pos == 0, "R4 wrap model", m_pos, 0);
        // Reference at position 84 (R5, R7).
        run_to(84);
        cyc(0, 8'h00, 8'h00, 0, 1, 1);
        // Reference exactly at the last position (R5).
        run_to(FRAME_LEN - 1);
        cyc(0, 8'h00, 8'h00, 0, 1, 0);
        // Reference at position 0 and at a mid-block position (R5).
        cyc(0, 8'h00, 8'h00, 0, 1, 0);
        run_to(2000);
        cyc(0, 8'h00, 8'h00, 0, 1, 1);
        // Nibble mode forces idle (R3).
        run_to(300);
        repeat (8) cyc(0, 8'h00, 8'h00, 1, 0, 1);
        // Other timing-reference code forces idle (R3).
        run_to(50);
        cyc(1, 8'h00, 8'h02, 0, 0, 1);
        repeat (8) cyc(0, 8'h00, 8'h00, 0, 1, 1);
        cyc(1, 8'h00, 8'h01, 0, 0, 1);
        // Constrained random traffic.
        for (int i = 0; i < 16000; i++) begin
            cyc(0, 8'($urandom_range(0, 3)), 8'h00, ($urandom_range(0, 999) == 0),
                ($urandom_range(0, 1499) == 0), 1'($urandom));
        end
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        #(20 * 150000);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog expired");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
            $finish;
        end
    end

endmodule